// File: doc/BRIEF.md
# Fully Associative Word Cache with Rotating Victim Pointer

This block is a small read-only cache in which a word may live in any of its entries. No index field exists: every lookup compares the tag of the requested address against all entries at once. Each entry has its own comparator. An entry only matches when its valid flag is set. When an entry matches, the block returns its stored word straight away. When nothing matches, the block fetches the word through a refill port and stores it in the entry chosen by one victim pointer. The response carries both the word and a hit flag.

The victim pointer uses a "not most recently used" rule. When an access touches the entry the pointer names, the pointer steps to the next entry, wrapping from the last entry to entry 0. When an access touches any other entry, the pointer stays where it is. A refill always counts as a touch of the pointed entry, so the pointer moves on after every miss.

All three data paths use valid/ready handshakes. A request transfers when `req_valid` and `req_ready` are both high at a clock edge. Only one request is in flight at a time, so `req_ready` stays low from the accepting edge until the response has transferred. While `rsp_valid` is high and `rsp_ready` is low, the response holds still. It waits as long as the consumer likes. The refill request follows the same rules toward memory. The refill return port takes one beat of data.

Top module: `fa_nmru_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0, and every entry is invalid, so the first access to any address is a miss.
- R2: An invalid entry never hits, even when its stored tag equals the tag of the address; after reset, an access to address 0 (whose tag matches the cleared tags) misses.
- R3: A hit returns the word last installed for that tag with `rsp_hit` = 1 and issues no refill request.
- R4: A miss issues exactly one refill request whose address is the request address with bits 1..0 forced to 0, holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`, and then answers with the refilled word and `rsp_hit` = 0.
- R5: A refill is written into the entry the pointer names, and the pointer then advances, wrapping from the last entry to 0; after a reset and N distinct misses with no pointed-entry hits, the (N+1)-th distinct miss evicts the word installed by the first.
- R6: A hit on the entry the pointer names advances the pointer by one, with the same wrap.
- R7: A hit on any entry other than the pointed one leaves the pointer unchanged, so the next miss replaces the same victim it would have replaced before that hit.
- R8: At most one entry matches in any lookup, so a hit returns exactly one entry's word.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_hit` do not change, and `req_ready` stays 0 until the response has transferred.
- R10: The tag is address bits 31..2; addresses that differ only in bits 1..0 hit the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Byte address to read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Word read |
| rsp_hit | output | 1 | 1 when the word came from the cache |
| mem_req_valid | output | 1 | Refill request present |
| mem_req_ready | input | 1 | Memory takes the refill request |
| mem_req_addr | output | 32 | Word-aligned refill address |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_ready | output | 1 | Block takes the refill word |
| mem_rsp_data | input | 32 | Refill word |

## Verification
A corrupted entry only appears at the ports when that tag is next looked up. It then shows as a wrong hit flag, wrong data, or a refill that should not have happened. A pointer that is off by one shows up later still, at the next miss, when the wrong word is evicted. The bench therefore keeps its own model of entry contents and victim position, and it uses address sequences that make a victim error visible within one or two accesses. One sequence fills the whole cache and then revisits the entry expected to have been evicted. Another hits the pointed entry and then misses. The bench checks response stability and the single-request rule on every clock.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_MREQ  = 3'd2,
    ST_MWAIT = 3'd3,
    ST_RESP  = 3'd4
  } fa_state_e;

endpackage

// File: rtl/fa_tag_store.sv
module fa_tag_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 30,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic               vld_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= wr_tag;
          dat_q[i] <= wr_data;
        end
      end
    end
  end

  // one comparator per entry
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
    end
  endgenerate

  always_comb begin
    lk_idx  = '0;
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx  = lk_idx | IDX_W'(i);
        lk_data = lk_data | dat_q[i];
      end
    end
  end

  assign lk_hit = |match;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R8

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))); // R5

endmodule

// File: rtl/fa_victim_ptr.sv
module fa_victim_ptr #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (touch_en && (touch_idx == ptr_q)) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R5

endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic rsp_valid,
  input  logic rsp_ready,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic mem_rsp_ready,
  input  logic lk_hit,
  output logic cap_en,
  output logic look_hit,
  output logic fill_en
);

  fa_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_LOOK;
      ST_LOOK:  state_d = lk_hit ? ST_RESP : ST_MREQ;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)     state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign cap_en        = req_ready && req_valid;
  assign look_hit      = (state_q == ST_LOOK) && lk_hit;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_rsp_ready = (state_q == ST_MWAIT);
  assign fill_en       = mem_rsp_ready && mem_rsp_valid;
  assign rsp_valid     = (state_q == ST_RESP);

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid); // R4

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> !req_ready); // R9

endmodule

// File: rtl/fa_nmru_cache.sv
module fa_nmru_cache #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned OFS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int unsigned TAG_W = ADDR_W - OFS_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  cur_tag;
  logic              lk_hit, cap_en, look_hit, fill_en;
  logic [IDX_W-1:0]  lk_idx, ptr, touch_idx;
  logic [DATA_W-1:0] lk_data, rdata_q;
  logic              rhit_q, touch_en;

  assign cur_tag = addr_q[ADDR_W-1:OFS_W];

  fa_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .lk_hit        (lk_hit),
    .cap_en        (cap_en),
    .look_hit      (look_hit),
    .fill_en       (fill_en)
  );

  fa_tag_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_tag  (cur_tag),
    .lk_hit  (lk_hit),
    .lk_idx  (lk_idx),
    .lk_data (lk_data),
    .wr_en   (fill_en),
    .wr_idx  (ptr),
    .wr_tag  (cur_tag),
    .wr_data (mem_rsp_data)
  );

  assign touch_en  = look_hit || fill_en;
  assign touch_idx = fill_en ? ptr : lk_idx;

  fa_victim_ptr #(
    .ENTRIES (ENTRIES)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .ptr       (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rdata_q <= '0;
      rhit_q  <= 1'b0;
    end else begin
      if (cap_en) addr_q <= req_addr;
      if (look_hit) begin
        rdata_q <= lk_data;
        rhit_q  <= 1'b1;
      end else if (fill_en) begin
        rdata_q <= mem_rsp_data;
        rhit_q  <= 1'b0;
      end
    end
  end

  assign rsp_data     = rdata_q;
  assign rsp_hit      = rhit_q;
  assign mem_req_addr = {cur_tag, {OFS_W{1'b0}}};

  AST_RSP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit)); // R9

  AST_MADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit && (lk_idx == ptr) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R6

  AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit && (lk_idx != ptr) |=> $stable(ptr)); // R7

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ptr != $past(ptr)); // R5

endmodule

// File: tb/test_fa_nmru_cache.sv
`timescale 1ns/1ps
module test_fa_nmru_cache;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  fa_nmru_cache i_fa_nmru_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  bit          m_vld [N];
  logic [29:0] m_tag [N];
  logic [31:0] m_dat [N];
  int          m_ptr = 0;

  int          mem_cnt = 0;
  logic [31:0] mem_seen = '0;
  int          mem_lat = 0;
  int          rsp_stall = 0;
  logic [31:0] rng = 32'h1ACE_B00C;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        repeat (mem_lat) @(negedge clk);
        mem_seen = mem_req_addr;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_cnt++;
        repeat (mem_lat) @(negedge clk);
        mem_rsp_data  = memfn(mem_seen);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // per-clock stability monitor
  logic        p_stall = 1'b0;
  logic [31:0] p_data = '0;
  logic        p_hit = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (p_stall) begin
        check(rsp_valid && rsp_data == p_data && rsp_hit == p_hit, "R9 response held",
              rsp_data, p_data);
        check(!req_ready, "R9 no accept while busy", {31'b0, req_ready}, 32'h0);
      end
      p_stall = rsp_valid && !rsp_ready;
      p_data  = rsp_data;
      p_hit   = rsp_hit;
    end
  end

  task automatic access(input logic [31:0] a, input string req);
    bit          e_hit = 0;
    int          e_idx = -1;
    logic [31:0] e_dat;
    int          m0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == a[31:2]) begin e_hit = 1; e_idx = i; end
    if (e_hit) begin
      e_dat = m_dat[e_idx];
      if (e_idx == m_ptr) m_ptr = (m_ptr + 1) % N;
    end else begin
      e_dat = memfn({a[31:2], 2'b00});
      m_vld[m_ptr] = 1; m_tag[m_ptr] = a[31:2]; m_dat[m_ptr] = e_dat;
      m_ptr = (m_ptr + 1) % N;
    end
    m0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (rsp_stall) @(negedge clk);
    rsp_ready = 1'b1;
    check(rsp_hit == e_hit, {req, " hit flag"}, {31'b0, rsp_hit}, {31'b0, e_hit});
    check(rsp_data == e_dat, {req, " data"}, rsp_data, e_dat);
    check(mem_cnt - m0 == (e_hit ? 0 : 1), {req, " refill count"}, mem_cnt - m0, e_hit ? 0 : 1);
    if (!e_hit)
      check(mem_seen == {a[31:2], 2'b00}, "R4 refill address", mem_seen, {a[31:2], 2'b00});
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);

    // R2: address 0 equals cleared tags yet must miss
    access(32'h0000_0000, "R2 invalid entry");
    // R10: other byte offset, same word -> hit; R7: entry 0 is not pointed
    access(32'h0000_0003, "R10 byte offset");
    // fill remaining entries, pointer wraps (R5)
    for (int i = 1; i < N; i++) access(32'h0000_1000 + 32'(i) * 4, "R5 fill");
    // R3/R8 hits across a full cache
    rsp_stall = 2;
    for (int i = 1; i < N; i += 9) access(32'h0000_1000 + 32'(i) * 4, "R3 R8 hit full");
    rsp_stall = 0;
    // R6: pointer back at entry 0 which holds address 0
    access(32'h0000_0000, "R6 pointed hit");
    access(32'h0000_9000, "R6 miss after step");
    access(32'h0000_1004, "R5 evicted word");
    access(32'h0000_0000, "R6 survivor");
    // R7: hit non-pointed entry, then miss replaces planned victim
    access(32'h0000_1040, "R7 other hit");
    access(32'h0000_9100, "R7 miss");
    access(32'h0000_100C, "R7 victim gone");
    access(32'h0000_1010, "R7 neighbour");
    // R9 stalls and mixed traffic
    for (int k = 0; k < 400; k++) begin
      rng = nxt(rng);
      mem_lat   = int'(rng[9:8]);
      rsp_stall = int'(rng[11:10]);
      access(32'h0002_0000 + 32'(rng[7:0] % 80) * 4 + 32'(rng[13:12]), "R3 R4 R5 mixed");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule